// File: doc/BRIEF.md
# IDE Host Interrupt Status and Mask Registers

This unit sits beside a two-channel IDE host controller and turns per-channel interrupt events into a host interrupt line for each channel. Each channel has two event sources: the attached drive and the bus-master transfer engine. A rising edge on either source latches a sticky status bit. Software clears the latched status through a per-channel clear strobe. A per-channel mask suppresses the channel's output. The output then passes through a per-channel polarity select, so that a channel can signal active-high or active-low, and is registered.

Software reaches the unit through a byte-wide register port at two offsets. Writing the control offset loads a chip mode byte, which holds the legacy-compatible/native selection and the test-mode flag. That write takes effect only when a key bit is set. Reading the same offset returns the channel-0 status. The mask offset carries both channel masks in its low bits. Channel-1 status and a board strap reporting a legacy header sit above the masks at that offset, and they are read-only.

Top module: `ide_irq_regs`

## Requirements
- R1: After reset, the legacy-mode and test-mode outputs are 0, both masks are 0, all status bits are 0, and irq_out is 0 until the first clock edge after reset is released.
- R2: A write to offset 2 with data bit 7 equal to 1 loads legacy_mode from data bit 1 and test_mode from data bit 0, both visible one clock later.
- R3: A write to offset 2 with data bit 7 equal to 0 leaves legacy_mode and test_mode unchanged.
- R4: A read at offset 2 returns channel-0 bus-master status in bit 1 and channel-0 drive status in bit 0. Bits 7 to 2 are 0.
- R5: A read at offset 3 returns legacy_strap in bit 4, channel-1 bus-master status in bit 3, channel-1 drive status in bit 2, the channel-1 mask in bit 1 and the channel-0 mask in bit 0. Bits 7 to 5 are 0.
- R6: A write to offset 3 loads the two masks from data bits 1:0. Data bits 2 to 4 have no effect on the status bits or on the strap readback.
- R7: A status bit becomes 1 in the clock after its event input rises. An event input that is held high does not set the bit again after it has been cleared.
- R8: A 1 on clr_stb[c] clears both status bits of channel c at the next clock edge. If an event rises in the same cycle, its status bit is set and not cleared.
- R9: irq_out[c] is registered from ((drive status OR bus-master status) AND NOT mask) XOR pol_low[c]. It therefore follows the status and mask state one clock later.
- R10: While channel c is masked, irq_out[c] holds the inactive level (pol_low[c]), and the channel's status bits keep their values.
- R11: Reads at offsets 0 and 1 return 0, and writes to those offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| drv_evt | input | 2 | Drive interrupt event per channel |
| bm_evt | input | 2 | Bus-master interrupt event per channel |
| clr_stb | input | 2 | Per-channel status clear strobe |
| pol_low | input | 2 | Per-channel output polarity, 1 means active-low |
| legacy_strap | input | 1 | Board strap: legacy header present |
| legacy_mode | output | 1 | Legacy-compatible mode selected |
| test_mode | output | 1 | Test mode selected |
| irq_out | output | 2 | Per-channel host interrupt line |

## Verification
The bench builds the unit with its default offsets: control at 2 and mask at 3, on a two-bit address. The two-bit address lets random traffic reach every offset, including the two unused ones. Random event, clear, polarity and strap patterns make event rises and clears land in the same cycle, and they exercise masking while status is pending. Directed sequences cover the key-bit rejection, held-high events after a clear, and mask writes that carry ones in the read-only bit positions.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

  localparam int NUM_CH = 2;
  localparam int BYTE_W = 8;
  localparam int KEY_BIT = 7;

  // Byte returned at the control offset: channel-0 status
  function automatic logic [BYTE_W-1:0] fn_ch0_byte(input logic bm, input logic drv);
    fn_ch0_byte = {{(BYTE_W-2){1'b0}}, bm, drv};
  endfunction

  // Byte returned at the mask offset
  function automatic logic [BYTE_W-1:0] fn_mask_byte(input logic strap, input logic bm1,
                                                      input logic drv1, input logic [1:0] msk);
    fn_mask_byte = {{(BYTE_W-5){1'b0}}, strap, bm1, drv1, msk};
  endfunction

  // Line level for one channel
  function automatic logic fn_irq_level(input logic pend, input logic masked, input logic pol_low);
    fn_irq_level = (pend & ~masked) ^ pol_low;
  endfunction

  function automatic logic fn_key_ok(input logic [BYTE_W-1:0] d);
    fn_key_ok = d[KEY_BIT];
  endfunction

endpackage

// File: rtl/ide_irq_chan_status.sv
module ide_irq_chan_status (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_evt,
  input  logic bm_evt,
  input  logic clr,
  output logic drv_rise,
  output logic bm_rise,
  output logic drv_st,
  output logic bm_st
);
  logic drv_prev, bm_prev;

  assign drv_rise = drv_evt & ~drv_prev;
  assign bm_rise  = bm_evt & ~bm_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_prev <= 1'b0;
      bm_prev  <= 1'b0;
      drv_st   <= 1'b0;
      bm_st    <= 1'b0;
    end else begin
      drv_prev <= drv_evt;
      bm_prev  <= bm_evt;
      // a new rise wins over a clear in the same cycle
      drv_st   <= drv_rise | (drv_st & ~clr);
      bm_st    <= bm_rise | (bm_st & ~clr);
    end
  end
endmodule

// File: rtl/ide_irq_ctrl_regs.sv
module ide_irq_ctrl_regs
  import ide_irq_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CTRL_OFS = 2,
  parameter int MASK_OFS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic              ctrl_wr_ok,
  output logic              ctrl_wr_rej,
  output logic              mask_wr,
  output logic              legacy_q,
  output logic              test_q,
  output logic [NUM_CH-1:0] mask_q
);
  logic ctrl_hit;

  assign ctrl_hit    = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
  assign ctrl_wr_ok  = ctrl_hit & fn_key_ok(reg_wdata);
  assign ctrl_wr_rej = ctrl_hit & ~fn_key_ok(reg_wdata);
  assign mask_wr     = reg_wr && (reg_addr == ADDR_W'(MASK_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy_q <= 1'b0;
      test_q   <= 1'b0;
      mask_q   <= '0;
    end else begin
      if (ctrl_wr_ok) begin
        legacy_q <= reg_wdata[1];
        test_q   <= reg_wdata[0];
      end
      if (mask_wr) mask_q <= reg_wdata[NUM_CH-1:0];
    end
  end
endmodule

// File: rtl/ide_irq_out_stage.sv
module ide_irq_out_stage
  import ide_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pend,
  input  logic [NUM_CH-1:0] mask,
  input  logic [NUM_CH-1:0] pol_low,
  output logic [NUM_CH-1:0] irq_out
);
  logic [NUM_CH-1:0] level_d;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lvl
    assign level_d[c] = fn_irq_level(pend[c], mask[c], pol_low[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= level_d;
  end
endmodule

// File: rtl/ide_irq_regs.sv
module ide_irq_regs
  import ide_irq_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CTRL_OFS = 2,
  parameter int MASK_OFS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [1:0]        drv_evt,
  input  logic [1:0]        bm_evt,
  input  logic [1:0]        clr_stb,
  input  logic [1:0]        pol_low,
  input  logic              legacy_strap,
  output logic              legacy_mode,
  output logic              test_mode,
  output logic [1:0]        irq_out
);
  logic [NUM_CH-1:0] drv_rise, bm_rise, drv_st, bm_st, pend, mask_q;
  logic ctrl_wr_ok, ctrl_wr_rej, mask_wr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ide_irq_chan_status u_st (
      .clk      (clk),
      .rst_n    (rst_n),
      .drv_evt  (drv_evt[c]),
      .bm_evt   (bm_evt[c]),
      .clr      (clr_stb[c]),
      .drv_rise (drv_rise[c]),
      .bm_rise  (bm_rise[c]),
      .drv_st   (drv_st[c]),
      .bm_st    (bm_st[c])
    );
    assign pend[c] = drv_st[c] | bm_st[c];
  end

  ide_irq_ctrl_regs #(
    .ADDR_W   (ADDR_W),
    .CTRL_OFS (CTRL_OFS),
    .MASK_OFS (MASK_OFS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .ctrl_wr_ok  (ctrl_wr_ok),
    .ctrl_wr_rej (ctrl_wr_rej),
    .mask_wr     (mask_wr),
    .legacy_q    (legacy_mode),
    .test_q      (test_mode),
    .mask_q      (mask_q)
  );

  ide_irq_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend),
    .mask    (mask_q),
    .pol_low (pol_low),
    .irq_out (irq_out)
  );

  always_comb begin
    if (reg_addr == ADDR_W'(CTRL_OFS))
      reg_rdata = fn_ch0_byte(bm_st[0], drv_st[0]);
    else if (reg_addr == ADDR_W'(MASK_OFS))
      reg_rdata = fn_mask_byte(legacy_strap, bm_st[1], drv_st[1], mask_q);
    else
      reg_rdata = '0;
  end
endmodule

// File: rtl/ide_irq_regs_chk.sv
module ide_irq_regs_chk #(
  parameter int ADDR_W   = 2,
  parameter int CTRL_OFS = 2,
  parameter int MASK_OFS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic [1:0]        clr_stb,
  input logic [1:0]        pol_low,
  input logic              legacy_mode,
  input logic              test_mode,
  input logic [1:0]        irq_out,
  input logic [1:0]        drv_rise,
  input logic [1:0]        drv_st,
  input logic [1:0]        bm_st,
  input logic [1:0]        mask_q
);
  AST_KEY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(CTRL_OFS) && reg_wdata[7]) |=>
      (legacy_mode == $past(reg_wdata[1]) && test_mode == $past(reg_wdata[0]))); // R2
  AST_KEY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(CTRL_OFS) && !reg_wdata[7]) |=>
      $stable({legacy_mode, test_mode})); // R3
  AST_CH0_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(CTRL_OFS)) |-> (reg_rdata[7:2] == 6'd0)); // R4
  AST_MASK_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(MASK_OFS)) |-> (reg_rdata[7:5] == 3'd0)); // R5

  for (genvar c = 0; c < 2; c++) begin : g_c
    AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      drv_rise[c] |=> drv_st[c]); // R7
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb[c] && !drv_rise[c]) |=> !drv_st[c]); // R8
    AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
      ((drv_st[c] || bm_st[c]) && !mask_q[c]) |=> (irq_out[c] == !$past(pol_low[c]))); // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[c] |=> (irq_out[c] == $past(pol_low[c]))); // R10
  end
endmodule

bind ide_irq_regs ide_irq_regs_chk #(
  .ADDR_W   (ADDR_W),
  .CTRL_OFS (CTRL_OFS),
  .MASK_OFS (MASK_OFS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .clr_stb     (clr_stb),
  .pol_low     (pol_low),
  .legacy_mode (legacy_mode),
  .test_mode   (test_mode),
  .irq_out     (irq_out),
  .drv_rise    (drv_rise),
  .drv_st      (drv_st),
  .bm_st       (bm_st),
  .mask_q      (mask_q)
);

// File: tb/tb_ide_irq_regs.sv
module tb_ide_irq_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd2;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] drv_evt = 2'b00, bm_evt = 2'b00, clr_stb = 2'b00, pol_low = 2'b00;
  logic       legacy_strap = 1'b0;
  logic       legacy_mode, test_mode;
  logic [1:0] irq_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [1:0] m_pd = 0, m_pb = 0, m_sd = 0, m_sb = 0, m_mask = 0, m_irq = 0;
  logic       m_leg = 0, m_test = 0;

  always #2.5 clk = ~clk;

  ide_irq_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drv_evt(drv_evt),
    .bm_evt(bm_evt), .clr_stb(clr_stb), .pol_low(pol_low),
    .legacy_strap(legacy_strap), .legacy_mode(legacy_mode),
    .test_mode(test_mode), .irq_out(irq_out)
  );

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd2:    return {6'd0, m_sb[0], m_sd[0]};
      2'd3:    return {3'd0, legacy_strap, m_sb[1], m_sd[1], m_mask};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    for (int c = 0; c < 2; c++) begin
      // line level from pre-edge state
      m_irq[c] = (((m_sd[c] | m_sb[c]) & ~m_mask[c]) ^ pol_low[c]);
      m_sd[c] = (drv_evt[c] & ~m_pd[c]) | (m_sd[c] & ~clr_stb[c]);
      m_sb[c] = (bm_evt[c] & ~m_pb[c]) | (m_sb[c] & ~clr_stb[c]);
    end
    m_pd = drv_evt;
    m_pb = bm_evt;
    if (reg_wr && reg_addr == 2'd2 && reg_wdata[7]) begin
      m_leg  = reg_wdata[1];
      m_test = reg_wdata[0];
    end
    if (reg_wr && reg_addr == 2'd3) m_mask = reg_wdata[1:0];
  endtask

  task automatic check_all();
    string t;
    t = (reg_addr == 2'd2) ? "R4 R7 R8" : (reg_addr == 2'd3) ? "R5 R6" : "R11";
    chk(t, reg_rdata, exp_rd(reg_addr));
    chk(m_mask != 0 ? "R9 R10 irq" : "R9 irq", {6'd0, irq_out}, {6'd0, m_irq});
    chk("R2/R3 mode", {6'd0, legacy_mode, test_mode}, {6'd0, m_leg, m_test});
  endtask

  task automatic step(input logic wr, input logic [1:0] a, input logic [7:0] d,
                      input logic [1:0] de, input logic [1:0] be, input logic [1:0] cl);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    drv_evt = de; bm_evt = be; clr_stb = cl;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    int seed;
    seed = 32'h1d3;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 mode", {6'd0, legacy_mode, test_mode}, 8'h00);
    chk("R1 irq", {6'd0, irq_out}, 8'h00);
    reg_addr = 2'd3;
    #0.1 chk("R1 mask byte", reg_rdata, 8'h00);
    rst_n = 1'b1;
    step(0, 2'd2, 8'h00, 2'b00, 2'b00, 2'b00);
    // R2 / R3 key bit
    step(1, 2'd2, 8'h83, 2'b00, 2'b00, 2'b00);
    chk("R2 load", {6'd0, legacy_mode, test_mode}, 8'h03);
    step(1, 2'd2, 8'h00, 2'b00, 2'b00, 2'b00);
    chk("R3 ignored", {6'd0, legacy_mode, test_mode}, 8'h03);
    step(1, 2'd2, 8'h80, 2'b00, 2'b00, 2'b00);
    chk("R2 reload", {6'd0, legacy_mode, test_mode}, 8'h00);
    // R7 set on rise, R9 registered line
    step(0, 2'd2, 8'h00, 2'b01, 2'b00, 2'b00);
    chk("R7 set", reg_rdata, 8'h01);
    chk("R9 not yet", {6'd0, irq_out}, 8'h00);
    step(0, 2'd2, 8'h00, 2'b01, 2'b00, 2'b00);
    chk("R9 asserted", {6'd0, irq_out}, 8'h01);
    step(0, 2'd2, 8'h00, 2'b01, 2'b00, 2'b01);
    chk("R8 cleared", reg_rdata, 8'h00);
    step(0, 2'd2, 8'h00, 2'b01, 2'b00, 2'b00);
    chk("R7 held no reset", reg_rdata, 8'h00);
    step(0, 2'd2, 8'h00, 2'b00, 2'b00, 2'b00);
    step(0, 2'd2, 8'h00, 2'b01, 2'b01, 2'b01);
    chk("R8 rise wins", reg_rdata, 8'h03);
    // R6 mask write with read-only bits set
    step(1, 2'd3, 8'hFF, 2'b00, 2'b00, 2'b00);
    chk("R6 mask byte", reg_rdata, 8'h03);
    step(0, 2'd2, 8'h00, 2'b00, 2'b00, 2'b00);
    chk("R10 masked line", {6'd0, irq_out}, 8'h00);
    chk("R10 status kept", reg_rdata, 8'h03);
    // R11 unused offsets
    step(1, 2'd0, 8'hFF, 2'b00, 2'b00, 2'b00);
    chk("R11 read", reg_rdata, 8'h00);
    step(1, 2'd1, 8'h83, 2'b00, 2'b00, 2'b00);
    chk("R11 no mode change", {6'd0, legacy_mode, test_mode}, 8'h00);
    step(1, 2'd3, 8'h00, 2'b00, 2'b00, 2'b11);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] de, be, cl;
      logic       wr;
      de = ($urandom_range(0, 3) == 0) ? 2'($urandom) : drv_evt;
      be = ($urandom_range(0, 3) == 0) ? 2'($urandom) : bm_evt;
      cl = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b00;
      wr = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 15) == 0) pol_low = 2'($urandom);
      if ($urandom_range(0, 31) == 0) legacy_strap = ~legacy_strap;
      step(wr, 2'($urandom), 8'($urandom), de, be, cl);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule